// File: doc/BRIEF.md
# Fine-Grain Thread Select Unit

This unit chooses which hardware thread of a fine-grain multithreaded scalar pipeline may issue in each cycle. Each thread supplies a ready bit and a flag saying whether its in-flight work assumes that a load will hit. The unit also keeps two stall flags per thread. One flag marks an outstanding cache miss. The other marks a wait on a long-latency operation. External set and clear pulses drive both flags.

A thread is eligible when it is ready and neither of its stall flags is set. Eligible threads fall into two tiers. Non-speculating threads are served first. Speculating threads are served only when no non-speculating thread is eligible. Within the chosen tier, a rotating pointer gives round-robin order. The pointer advances past the granted thread only in cycles that produce a grant. The grant is combinational from the current inputs and the registered flags and pointer, so a pipeline can use it in the same cycle.

Top module: `thread_pick`

## Requirements
- R1: After reset the pointer is at thread 0 and both stall flags of every thread are clear. With all threads ready and none speculating, the first grant goes to thread 0 (grant bit 0).
- R2: `grant` has exactly one bit set whenever `grant_valid` is high. It is all zero whenever `grant_valid` is low. Bit i of `grant` means thread i.
- R3: Within the tier being served, the grant goes to the first requesting thread at or after the pointer, counting upward and wrapping from THREADS-1 to 0. After a grant to thread i, the pointer becomes (i+1) mod THREADS.
- R4: A thread whose `spec` bit is high is granted only when no eligible thread has its `spec` bit low.
- R5: A `miss_set` pulse on bit i makes thread i ineligible from the next cycle on. A `miss_clr` pulse makes it eligible again from the cycle after the pulse, not during the pulse. If set and clear come in the same cycle, set wins.
- R6: `slow_set` and `slow_clr` drive the long-latency stall flag with the same timing and the same set-wins rule as R5.
- R7: A thread whose `ready` bit is low is never granted.
- R8: When no thread is eligible, `grant_valid` is low and the pointer keeps its value. The next grant therefore starts its search from the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | input | THREADS | Thread has an instruction to issue |
| spec | input | THREADS | Thread's work assumes a load hit |
| miss_set | input | THREADS | Pulse: a cache miss is now outstanding |
| miss_clr | input | THREADS | Pulse: the cache miss has resolved |
| slow_set | input | THREADS | Pulse: a long-latency operation has started |
| slow_clr | input | THREADS | Pulse: the long-latency operation is done |
| grant | output | THREADS | One-hot thread selected this cycle |
| grant_valid | output | 1 | A thread was selected this cycle |

## Verification
The bench builds the unit with the default of four threads. At that size a short sequence can take the pointer through every position, including the wrap from thread 3 back to thread 0. The vector table holds the pointer fixed across empty cycles and mixes the two tiers so that the low tier wraps past the pointer. The directed cases cover the timing of flag set and clear, the case where set and clear arrive together, and a miss that forces a speculating thread to be chosen.

// File: rtl/thread_pick.sv
module thread_pick #(
  parameter int THREADS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [THREADS-1:0] ready,
  input  logic [THREADS-1:0] spec,
  input  logic [THREADS-1:0] miss_set,
  input  logic [THREADS-1:0] miss_clr,
  input  logic [THREADS-1:0] slow_set,
  input  logic [THREADS-1:0] slow_clr,
  output logic [THREADS-1:0] grant,
  output logic               grant_valid
);
  localparam int IW = (THREADS > 1) ? $clog2(THREADS) : 1;

  logic [IW-1:0]      ptr;
  logic [THREADS-1:0] miss_q, slow_q;
  logic [THREADS-1:0] elig, hi_req, lo_req, pick;
  logic [IW-1:0]      nxt_ptr;

  function automatic logic [THREADS-1:0] rr_pick(input logic [THREADS-1:0] req,
                                                 input logic [IW-1:0] start);
    rr_pick = '0;
    for (int k = THREADS - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(start) + k) % THREADS;
      if (req[idx]) begin
        rr_pick = '0;
        rr_pick[idx] = 1'b1;
      end
    end
  endfunction

  assign elig   = ready & ~miss_q & ~slow_q;
  assign hi_req = elig & ~spec;
  assign lo_req = elig & spec;
  assign pick   = (|hi_req) ? rr_pick(hi_req, ptr) : rr_pick(lo_req, ptr);

  assign grant       = pick;
  assign grant_valid = |elig;

  always_comb begin
    nxt_ptr = ptr;
    for (int i = 0; i < THREADS; i++)
      if (pick[i]) nxt_ptr = (i == THREADS - 1) ? '0 : IW'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      miss_q <= '0;
      slow_q <= '0;
    end else begin
      ptr    <= nxt_ptr;
      miss_q <= (miss_q & ~miss_clr) | miss_set;
      slow_q <= (slow_q & ~slow_clr) | slow_set;
    end
  end
endmodule

// File: rtl/thread_pick_chk.sv
module thread_pick_chk #(
  parameter int THREADS = 4,
  parameter int IW = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [THREADS-1:0] ready,
  input logic [THREADS-1:0] spec,
  input logic [THREADS-1:0] miss_set,
  input logic [THREADS-1:0] slow_set,
  input logic [THREADS-1:0] miss_q,
  input logic [THREADS-1:0] slow_q,
  input logic [THREADS-1:0] grant,
  input logic               grant_valid,
  input logic [IW-1:0]      ptr
);
  logic [IW-1:0] after_grant;
  always_comb begin
    after_grant = '0;
    for (int i = 0; i < THREADS; i++)
      if (grant[i]) after_grant = (i == THREADS - 1) ? '0 : IW'(i + 1);
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $countones(grant) == 1);

  // R2
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> grant == '0);

  // R3
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> ptr == $past(after_grant));

  // R4
  spec_tier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && (grant & spec) != '0) |-> (ready & ~spec & ~miss_q & ~slow_q) == '0);

  // R5
  miss_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (grant & $past(miss_set)) == '0);

  // R6
  slow_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (grant & $past(slow_set)) == '0);

  // R7
  not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~ready) == '0);

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |=> ptr == $past(ptr));
endmodule

bind thread_pick thread_pick_chk #(.THREADS(THREADS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .spec(spec),
  .miss_set(miss_set), .slow_set(slow_set), .miss_q(miss_q), .slow_q(slow_q),
  .grant(grant), .grant_valid(grant_valid), .ptr(ptr)
);

// File: tb/sim_thread_pick.sv
module sim_thread_pick;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] ready = '0, spec = '0, mset = '0, mclr = '0, sset = '0, sclr = '0;
  logic [N-1:0] grant;
  logic         grant_valid;
  int runs = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  thread_pick #(.THREADS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .ready(ready), .spec(spec),
    .miss_set(mset), .miss_clr(mclr), .slow_set(sset), .slow_clr(sclr),
    .grant(grant), .grant_valid(grant_valid)
  );

  // {ready, spec, valid, grant}; the pointer carries over from row to row
  localparam logic [12:0] VEC [15] = '{
    {4'b1111, 4'b0000, 1'b1, 4'b0001},
    {4'b1111, 4'b0000, 1'b1, 4'b0010},
    {4'b1111, 4'b0000, 1'b1, 4'b0100},
    {4'b1111, 4'b0000, 1'b1, 4'b1000},
    {4'b0000, 4'b0000, 1'b0, 4'b0000},
    {4'b1010, 4'b0000, 1'b1, 4'b0010},
    {4'b1010, 4'b0000, 1'b1, 4'b1000},
    {4'b1111, 4'b1110, 1'b1, 4'b0001},
    {4'b1111, 4'b1110, 1'b1, 4'b0001},
    {4'b0110, 4'b0110, 1'b1, 4'b0010},
    {4'b0110, 4'b0010, 1'b1, 4'b0100},
    {4'b0110, 4'b0110, 1'b1, 4'b0010},
    {4'b0001, 4'b0001, 1'b1, 4'b0001},
    {4'b0000, 4'b1111, 1'b0, 4'b0000},
    {4'b1111, 4'b0000, 1'b1, 4'b0010}
  };

  task automatic apply(input logic [N-1:0] r, input logic [N-1:0] s,
                       input logic [N-1:0] ms, input logic [N-1:0] mc,
                       input logic [N-1:0] ss, input logic [N-1:0] sc);
    @(negedge clk);
    ready = r; spec = s; mset = ms; mclr = mc; sset = ss; sclr = sc;
    #2;
  endtask

  task automatic check(input string req, input logic ev, input logic [N-1:0] eg);
    runs++;
    if (grant_valid !== ev || grant !== eg) begin
      fails++;
      $display("FAIL %s: got valid=%b grant=%b, expected valid=%b grant=%b",
               req, grant_valid, grant, ev, eg);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    apply('0, '0, '0, '0, '0, '0);
    check("R1 idle after reset", 1'b0, 4'b0000);

    for (int i = 0; i < 15; i++) begin
      apply(VEC[i][12:9], VEC[i][8:5], '0, '0, '0, '0);
      check($sformatf("R3/R4/R8 vector %0d", i), VEC[i][4], VEC[i][3:0]);
    end
    // pointer now at 2

    apply('0, '0, 4'b0100, '0, '0, '0);
    check("R5 set pulse cycle", 1'b0, 4'b0000);
    apply(4'b0100, '0, '0, '0, '0, '0);
    check("R5 miss blocks thread 2", 1'b0, 4'b0000);
    apply(4'b0100, '0, '0, 4'b0100, '0, '0);
    check("R5 clear not yet in effect", 1'b0, 4'b0000);
    apply(4'b0100, '0, '0, '0, '0, '0);
    check("R5 thread 2 eligible after clear", 1'b1, 4'b0100);
    // pointer 3

    apply('0, '0, '0, '0, 4'b1000, '0);
    check("R6 set pulse cycle", 1'b0, 4'b0000);
    apply(4'b1000, '0, '0, '0, '0, '0);
    check("R6 long-latency blocks thread 3", 1'b0, 4'b0000);
    apply(4'b1001, '0, '0, '0, '0, '0);
    check("R6 skip stalled thread 3, wrap to 0", 1'b1, 4'b0001);
    // pointer 1
    apply('0, '0, '0, '0, 4'b1000, 4'b1000);
    check("R6 set+clear cycle", 1'b0, 4'b0000);
    apply(4'b1000, '0, '0, '0, '0, '0);
    check("R6 set wins over clear", 1'b0, 4'b0000);
    apply('0, '0, '0, '0, '0, 4'b1000);
    check("R8 nothing ready", 1'b0, 4'b0000);
    apply(4'b1000, '0, '0, '0, '0, '0);
    check("R6 thread 3 eligible after clear", 1'b1, 4'b1000);
    // pointer 0

    apply('0, '0, 4'b0001, '0, '0, '0);
    check("R5 miss set on thread 0", 1'b0, 4'b0000);
    apply(4'b0011, 4'b0010, '0, '0, '0, '0);
    check("R4 speculating thread wins when the other is missed", 1'b1, 4'b0010);
    apply(4'b1110, 4'b1111, '0, '0, '0, '0);
    check("R7 thread 0 not ready, low tier from ptr 2", 1'b1, 4'b0100);

    rst_n = 1'b0;
    apply('0, '0, 4'b0010, '0, 4'b0100, '0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(4'b1111, '0, '0, '0, '0, '0);
    check("R1 reset clears flags and pointer", 1'b1, 4'b0001);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule